// File: doc/BRIEF.md
# Serial Address and Mode Command Decoder

This block sits in front of the array controller of a video field store. It collects two serially delivered 8-bit words on a dedicated address clock: a row address on one line, and a column-plus-mode word on the other. Each line carries its bits least significant first. When the row strobe falls, the block captures both words. It splits the second word into a 6-bit column and a 2-bit operation code, and it issues exactly one command pulse. The command is one of: a read into holding latch A, a read into holding latch B, a write from input latch C, or a refresh.

For a refresh, the block ignores the external address. It supplies a row from an internal counter that steps through all 212 array rows and wraps. Row addresses outside the array are rejected with a separate pulse. After reset, the block swallows the first eight strobes as warm-up cycles and then raises a ready flag.

All inputs are sampled on the system clock `clk`. Edges of the address clock and of the strobe are found by comparing each input with its value on the previous cycle.

Top module: `sam_cmd_decoder`

## Requirements
- R1: After reset, `ready` is low and all five pulse outputs are low.
- R2: On each rising edge of `addr_clk`, one bit from `row_sdi` and one bit from `col_sdi` are shifted in, least significant bit first. The last 8 bits received on each line form the row word and the column/mode word.
- R3: A falling edge of `strobe_n` captures both words. Any resulting pulse appears in the clock cycle after the edge is seen and lasts exactly one cycle.
- R4: In the column/mode word, bits 5..0 are the column, bit 7 is M1 and bit 6 is M0. Mode {M1,M0} = 00 pulses `rd_a_pulse`, 01 pulses `rd_b_pulse` and 10 pulses `wr_c_pulse`. Each of these presents the captured row on `row_out` and the captured column on `col_out`.
- R5: In any cycle, at most one of `rd_a_pulse`, `rd_b_pulse`, `wr_c_pulse`, `refresh_pulse` and `bad_row_pulse` is high.
- R6: Mode 11 pulses `refresh_pulse`. During that pulse, `row_out` holds the internal refresh row and `col_out` is 0, whatever the shifted-in words contain.
- R7: The refresh row is 0 after reset and advances by one after each issued refresh. It wraps from 211 back to 0.
- R8: In modes 00, 01 and 10, a row word of 212 or above produces `bad_row_pulse` and no operation pulse.
- R9: The first eight strobe falls after reset produce no pulse of any kind, and do not advance the refresh row. `ready` rises with the eighth fall and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_clk | input | 1 | Address shift clock, sampled on clk |
| row_sdi | input | 1 | Serial row address bit |
| col_sdi | input | 1 | Serial column/mode bit |
| strobe_n | input | 1 | Row strobe, active on its falling edge |
| rd_a_pulse | output | 1 | Read into latch A command |
| rd_b_pulse | output | 1 | Read into latch B command |
| wr_c_pulse | output | 1 | Write from latch C command |
| refresh_pulse | output | 1 | Refresh command |
| bad_row_pulse | output | 1 | Rejected out-of-range row |
| row_out | output | 8 | Row for the issued command |
| col_out | output | 6 | Column for the issued command |
| ready | output | 1 | Warm-up strobes complete |

## Verification
The bench targets the boundary between the seventh, eighth and ninth strobes. A decoder that miscounts the warm-up either leaks a command early or swallows the first real one. Rows 211 and 212 are both applied. An off-by-one in the range test would either reject the last valid row or pass a row outside the array. More than 212 refreshes are issued in a row, so that a counter that fails to wrap, or wraps at a power of two, presents a wrong row. A refresh is sent with a nonzero external address and column to catch a design that leaks the external address into the refresh. Asymmetric bit patterns expose a reversed shift direction or swapped mode bits.

// File: rtl/sam_cmd_pkg.sv
package sam_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_RD_A    = 2'b00,
    MODE_RD_B    = 2'b01,
    MODE_WR_C    = 2'b10,
    MODE_REFRESH = 2'b11
  } mode_e;

  // True when the row lies inside an array of num_rows rows.
  function automatic bit row_in_range(input int unsigned row, input int unsigned num_rows);
    return row < num_rows;
  endfunction

  // Successor of a refresh row, wrapping at the last row.
  function automatic int unsigned refresh_next(input int unsigned row, input int unsigned num_rows);
    return (row + 1 >= num_rows) ? 0 : row + 1;
  endfunction

endpackage

// File: rtl/sam_edge_det.sv
module sam_edge_det #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic edge_seen
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= FALLING;
    else        prev_q <= sig;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_seen = prev_q & ~sig;
    end else begin : g_rise
      assign edge_seen = ~prev_q & sig;
    end
  endgenerate
endmodule

// File: rtl/sam_serial_word.sv
module sam_serial_word #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sdi,
  output logic [WIDTH-1:0] word
);
  // LSB-first: each new bit enters at the top, so the first bit ends at bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {sdi, word[WIDTH-1:1]};
  end
endmodule

// File: rtl/sam_init_gate.sv
module sam_init_gate #(
  parameter int INIT_STROBES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_evt,
  output logic ready
);
  localparam int CNT_W = $clog2(INIT_STROBES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_STROBES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (strobe_evt && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == LAST);
endmodule

// File: rtl/sam_cmd_decoder.sv
module sam_cmd_decoder
  import sam_cmd_pkg::*;
#(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 6,
  parameter int NUM_ROWS     = 212,
  parameter int INIT_STROBES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_clk,
  input  logic             row_sdi,
  input  logic             col_sdi,
  input  logic             strobe_n,
  output logic             rd_a_pulse,
  output logic             rd_b_pulse,
  output logic             wr_c_pulse,
  output logic             refresh_pulse,
  output logic             bad_row_pulse,
  output logic [ROW_W-1:0] row_out,
  output logic [COL_W-1:0] col_out,
  output logic             ready
);
  localparam int CW_W = COL_W + 2;

  logic             addr_rise;
  logic             strobe_fall;
  logic [ROW_W-1:0] row_word;
  logic [CW_W-1:0]  cm_word;
  logic [ROW_W-1:0] ref_row_q;
  mode_e            mode;
  logic             row_ok;
  logic             cmd_evt;

  sam_edge_det #(.FALLING(1'b0)) u_addr_edge (
    .clk(clk), .rst_n(rst_n), .sig(addr_clk), .edge_seen(addr_rise));

  sam_edge_det #(.FALLING(1'b1)) u_strobe_edge (
    .clk(clk), .rst_n(rst_n), .sig(strobe_n), .edge_seen(strobe_fall));

  sam_serial_word #(.WIDTH(ROW_W)) u_row_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(addr_rise), .sdi(row_sdi), .word(row_word));

  sam_serial_word #(.WIDTH(CW_W)) u_cm_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(addr_rise), .sdi(col_sdi), .word(cm_word));

  sam_init_gate #(.INIT_STROBES(INIT_STROBES)) u_init (
    .clk(clk), .rst_n(rst_n), .strobe_evt(strobe_fall), .ready(ready));

  assign mode    = mode_e'(cm_word[CW_W-1 -: 2]);
  assign row_ok  = row_in_range(int'(row_word), NUM_ROWS);
  assign cmd_evt = strobe_fall & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_a_pulse    <= 1'b0;
      rd_b_pulse    <= 1'b0;
      wr_c_pulse    <= 1'b0;
      refresh_pulse <= 1'b0;
      bad_row_pulse <= 1'b0;
      row_out       <= '0;
      col_out       <= '0;
      ref_row_q     <= '0;
    end else begin
      rd_a_pulse    <= 1'b0;
      rd_b_pulse    <= 1'b0;
      wr_c_pulse    <= 1'b0;
      refresh_pulse <= 1'b0;
      bad_row_pulse <= 1'b0;
      if (cmd_evt) begin
        if (mode == MODE_REFRESH) begin
          refresh_pulse <= 1'b1;
          row_out       <= ref_row_q;
          col_out       <= '0;
          ref_row_q     <= ROW_W'(refresh_next(int'(ref_row_q), NUM_ROWS));
        end else if (!row_ok) begin
          bad_row_pulse <= 1'b1;
        end else begin
          row_out <= row_word;
          col_out <= cm_word[COL_W-1:0];
          case (mode)
            MODE_RD_A: rd_a_pulse <= 1'b1;
            MODE_RD_B: rd_b_pulse <= 1'b1;
            default:   wr_c_pulse <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sam_cmd_decoder_chk.sv
module sam_cmd_decoder_chk #(
  parameter int ROW_W    = 8,
  parameter int COL_W    = 6,
  parameter int NUM_ROWS = 212
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_a_pulse,
  input logic             rd_b_pulse,
  input logic             wr_c_pulse,
  input logic             refresh_pulse,
  input logic             bad_row_pulse,
  input logic [ROW_W-1:0] row_out,
  input logic [COL_W-1:0] col_out,
  input logic             ready
);
  logic [4:0] pulses;
  assign pulses = {rd_a_pulse, rd_b_pulse, wr_c_pulse, refresh_pulse, bad_row_pulse};

  a_r5_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses != 5'b0) |=> (pulses == 5'b0));

  a_r9_quiet_in_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (pulses == 5'b0));

  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r8_row_in_array: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_pulse || rd_b_pulse || wr_c_pulse || refresh_pulse) |-> (int'(row_out) < NUM_ROWS));

  a_r6_refresh_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |-> (col_out == '0));
endmodule

bind sam_cmd_decoder sam_cmd_decoder_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .NUM_ROWS(NUM_ROWS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_a_pulse(rd_a_pulse), .rd_b_pulse(rd_b_pulse), .wr_c_pulse(wr_c_pulse),
  .refresh_pulse(refresh_pulse), .bad_row_pulse(bad_row_pulse),
  .row_out(row_out), .col_out(col_out), .ready(ready)
);

// File: tb/sam_cmd_decoder_bench.sv
`timescale 1ns/1ps
module sam_cmd_decoder_bench;
  localparam int NROWS = 212;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_clk = 1'b0;
  logic row_sdi = 1'b0;
  logic col_sdi = 1'b0;
  logic strobe_n = 1'b1;
  logic rd_a_pulse, rd_b_pulse, wr_c_pulse, refresh_pulse, bad_row_pulse, ready;
  logic [7:0] row_out;
  logic [5:0] col_out;

  always #2.5 clk = ~clk;

  sam_cmd_decoder u_sam_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .row_sdi(row_sdi),
    .col_sdi(col_sdi), .strobe_n(strobe_n), .rd_a_pulse(rd_a_pulse),
    .rd_b_pulse(rd_b_pulse), .wr_c_pulse(wr_c_pulse),
    .refresh_pulse(refresh_pulse), .bad_row_pulse(bad_row_pulse),
    .row_out(row_out), .col_out(col_out), .ready(ready));

  // kinds: 0 read A, 1 read B, 2 write C, 3 refresh, 4 bad row, 7 several
  typedef struct { int kind; int row; int col; } item_t;
  item_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  int strobes_seen = 0;
  int ref_row = 0;
  bit done = 1'b0;

  function automatic string req_of(input int kind);
    case (kind)
      3:       return "R6/R7";
      4:       return "R8";
      7:       return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: shift both words LSB first, then fall the strobe; push expectation.
  task automatic send(input int row, input int col, input int mode);
    logic [7:0] rw;
    logic [7:0] cw;
    item_t it;
    rw = 8'(row);
    cw = {2'(mode), 6'(col)};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      addr_clk = 1'b0; row_sdi = rw[i]; col_sdi = cw[i];
      @(negedge clk);
      addr_clk = 1'b1;
      @(negedge clk);
    end
    addr_clk = 1'b0;
    if (strobes_seen >= 8) begin
      if (mode == 3) begin
        it = '{kind: 3, row: ref_row, col: 0};
        ref_row = (ref_row == NROWS - 1) ? 0 : ref_row + 1;
      end else if (row >= NROWS) begin
        it = '{kind: 4, row: 0, col: 0};
      end else begin
        it = '{kind: mode, row: row, col: col};
      end
      exp_q.push_back(it);
    end
    strobes_seen++;
    @(negedge clk); strobe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); strobe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pop and compare whenever any pulse appears.
  always @(negedge clk) begin
    if (rst_n) begin
      int n;
      int kind;
      item_t e;
      n = rd_a_pulse + rd_b_pulse + wr_c_pulse + refresh_pulse + bad_row_pulse;
      if (n != 0) begin
        kind = (n > 1) ? 7 : rd_a_pulse ? 0 : rd_b_pulse ? 1 : wr_c_pulse ? 2 :
               refresh_pulse ? 3 : 4;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected pulse", kind, -1);
        end else begin
          e = exp_q.pop_front();
          check(kind == e.kind, req_of(e.kind), kind, e.kind);
          if (e.kind != 4 && kind == e.kind) begin
            check(int'(row_out) == e.row, "R2 row", int'(row_out), e.row);
            check(int'(col_out) == e.col, "R2 col", int'(col_out), e.col);
          end
        end
      end
    end
  end

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready == 1'b0, "R1 ready", ready, 0);
    check({rd_a_pulse, rd_b_pulse, wr_c_pulse, refresh_pulse, bad_row_pulse} == 5'b0,
          "R1 pulses", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 warm-up: seven strobes, nothing issued (monitor flags any pulse)
    for (int k = 0; k < 7; k++) send(5 + k, k, k % 4);
    check(ready == 1'b0, "R9 ready after 7", ready, 0);
    send(9, 1, 3);
    check(ready == 1'b1, "R9 ready after 8", ready, 1);
    // R4 decoding
    send(10, 3, 0);
    send(211, 63, 1);
    send(0, 17, 2);
    send(8'hA5, 6'h2A, 0);
    // R8 range
    send(212, 5, 0);
    send(255, 1, 2);
    // R6 refresh ignores external address; R7 wrap after 212 refreshes
    send(99, 44, 3);
    for (int k = 0; k < NROWS + 2; k++) send(k % 256, 63 - (k % 64), 3);
    send(7, 9, 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 missing pulse", exp_q.size(), 0);
    check(ready == 1'b1, "R9 ready sticky", ready, 1);
    done = 1'b1;
    report();
  end
endmodule